// File: doc/BRIEF.md
# Concurrent Sweep and Allocation Engine

This engine owns the pool of free object slots in a fixed-shape object heap of N slots, where slot 0 stands for the null pointer. It answers the mutator's allocation requests from a last-in, first-out stack of free addresses. When an allocation leaves the stack shallower than a threshold, it emits a one-cycle pulse that starts a collection. Root capture and marking happen outside this block. Once the marking logic reports that tracing has finished, the engine walks the heap one slot per cycle. It reads each slot's mark bit from the shared mark map and clears that bit. It returns dead objects to the free stack and reports each one on a clear output, so the pointer storage can zero it.

A two-bit state per slot tells the sweep apart from the mutator. The states are free, freshly allocated and survivor. Because of them, allocation keeps running while the sweep is in progress. An allocation pre-empts the sweep step of its cycle. A reclaimed address can be pushed in the same cycle that an allocation pops. Allocation requests are always accepted. There is no back-pressure: the request pin has no ready partner, and every request gets a result in the next cycle. The result is either an address or an out-of-memory indication.

Top module: `reclaim_alloc_engine`

## Requirements
- R1: After reset the free stack holds addresses 1 to N-1, with N-1 on top. Every slot state is free (00). No output pulse is asserted. Successive allocations with no reclaim return N-1, N-2, and so on down to 1.
- R2: An allocation request in cycle t yields `alloc_vld`=1 in cycle t+1. `alloc_addr` then carries the address that was on top of the free stack, and the stack shrinks by one. The slot state becomes freshly allocated (01). `alloc_vld` is 0 in every cycle that does not follow a request.
- R3: A request made while the free stack is empty yields `alloc_addr`=0 with `oom`=1. `oom` is 0 on every successful allocation.
- R4: `gc_start` is a one-cycle pulse in cycle t+1 after an allocation in cycle t that leaves fewer than THRESH entries on the stack. It fires only when no collection is in progress. No second pulse comes before the sweep of the current collection has finished.
- R5: `trace_done` matters only while the engine waits for tracing. In the next cycle the sweep visits slot 1: `mark_clr`=1 with `mark_addr`=1. Each later visit takes the next slot. The visit of slot N-1 is the last. `trace_done` at any other time has no effect.
- R6: In a cycle with an allocation request, no sweep step happens. `mark_clr` is 0 and the same slot is visited in the next cycle without a request.
- R7: A visited slot whose mark bit is 1 becomes a survivor (10). It is not reclaimed in this sweep.
- R8: A visited slot with mark bit 0 and state 10 becomes free (00). The cycle after the visit shows `clear_valid`=1 with `clear_addr` equal to that slot, and the address is pushed onto the free stack.
- R9: A visited unmarked slot in state 01 keeps its state. A visited slot in state 00 is skipped. Neither produces `clear_valid`.
- R10: When a reclaim push and an allocation fall into the same cycle, the allocation returns the old top entry. The reclaimed address takes its place and the stack depth does not change.
- R11: Every visited slot has its mark bit cleared through `mark_clr`, so the mark map is all zero when a sweep ends. The engine never sets a mark bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request, accepted every cycle |
| alloc_vld | output | 1 | Allocation result valid, one cycle after the request |
| alloc_addr | output | $clog2(N) | Allocated slot address (0 when out of memory) |
| oom | output | 1 | Free stack was empty for this request |
| gc_start | output | 1 | One-cycle collection start pulse |
| trace_done | input | 1 | Tracing has finished, so the sweep may begin |
| mark_addr | output | $clog2(N) | Slot whose mark bit is read and cleared |
| mark_bit | input | 1 | Mark bit of `mark_addr`, read in the same cycle |
| mark_clr | output | 1 | Clear the mark bit at `mark_addr` this cycle |
| clear_valid | output | 1 | A reclaimed slot is being released |
| clear_addr | output | $clog2(N) | Address of the reclaimed slot |

## Verification
Allocation results, the out-of-memory flag and the start pulse all come from the request cycle t and are due in cycle t+1. The bench compares them at the falling edge after the next rising edge, against a cycle-stepped model of stack, slot states and phase. `mark_clr` and `mark_addr` are combinational in the visit cycle, so they are sampled one time unit after the inputs are driven. `clear_valid` and `clear_addr` trail the visit by one cycle and are checked in the same delayed slot as the allocation outputs. Marks are cleared in the bench's mark map only at the falling edge after a `mark_clr`, so the mark value the engine reads is never altered before its edge.

// File: rtl/rae_pkg.sv
package rae_pkg;
  // per-slot occupancy state
  typedef enum logic [1:0] {
    SL_FREE  = 2'b00,
    SL_FRESH = 2'b01,
    SL_KEPT  = 2'b10
  } slot_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'b00,
    PH_TRACE = 2'b01,
    PH_SWEEP = 2'b10
  } phase_t;
endpackage

// File: rtl/rae_free_stack.sv
module rae_free_stack #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] pop_addr,
  output logic          empty,
  output logic [AW-1:0] lvl_nxt
);
  logic [AW-1:0] stk [N];
  logic [AW-1:0] top;
  logic          pop_ok;

  assign empty    = (top == '0);
  assign pop_ok   = pop && !empty;
  assign pop_addr = empty ? '0 : stk[top - 1'b1];

  always_comb begin
    lvl_nxt = top;
    if (pop_ok && !push)      lvl_nxt = top - 1'b1;
    else if (!pop_ok && push) lvl_nxt = top + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) stk[i] <= AW'((i + 1) % N);
      top <= AW'(N - 1);
    end else begin
      if (pop_ok && push)  stk[top - 1'b1] <= push_addr; // swap in place
      else if (push)       stk[top] <= push_addr;
      top <= lvl_nxt;
    end
  end
endmodule

// File: rtl/rae_slot_map.sv
module rae_slot_map #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fresh_en,
  input  logic [AW-1:0]     fresh_addr,
  input  logic              sw_en,
  input  logic [AW-1:0]     sw_addr,
  input  rae_pkg::slot_t    sw_val,
  output rae_pkg::slot_t    sw_rd
);
  import rae_pkg::*;
  slot_t map [N];

  assign sw_rd = map[sw_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) map[i] <= SL_FREE;
    end else begin
      if (sw_en)    map[sw_addr]    <= sw_val;
      if (fresh_en) map[fresh_addr] <= SL_FRESH;
    end
  end
endmodule

// File: rtl/rae_sweep_ctrl.sv
module rae_sweep_ctrl #(
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic              low,
  input  logic              trace_done,
  input  logic              mark_bit,
  input  rae_pkg::slot_t    slot_rd,
  output logic [AW-1:0]     ptr,
  output logic              visit,
  output logic              slot_we,
  output rae_pkg::slot_t    slot_wv,
  output logic              gc_start,
  output logic              rec_v,
  output logic [AW-1:0]     rec_a
);
  import rae_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  phase_t phase;
  logic   dead;

  assign visit   = (phase == PH_SWEEP) && !alloc_req;
  assign dead    = !mark_bit && (slot_rd == SL_KEPT);
  assign slot_we = visit && (mark_bit || dead);
  assign slot_wv = mark_bit ? SL_KEPT : SL_FREE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      ptr      <= '0;
      gc_start <= 1'b0;
      rec_v    <= 1'b0;
      rec_a    <= '0;
    end else begin
      gc_start <= 1'b0;
      rec_v    <= 1'b0;
      case (phase)
        PH_IDLE: if (alloc_req && low) begin
          gc_start <= 1'b1;
          phase    <= PH_TRACE;
        end
        PH_TRACE: if (trace_done) begin
          phase <= PH_SWEEP;
          ptr   <= AW'(1);
        end
        PH_SWEEP: if (visit) begin
          if (dead) begin
            rec_v <= 1'b1;
            rec_a <= ptr;
          end
          if (ptr == LAST) phase <= PH_IDLE;
          else             ptr   <= ptr + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reclaim_alloc_engine.sv
module reclaim_alloc_engine #(
  parameter int N      = 16,
  parameter int THRESH = N / 4,
  localparam int AW    = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_req,
  output logic          alloc_vld,
  output logic [AW-1:0] alloc_addr,
  output logic          oom,
  output logic          gc_start,
  input  logic          trace_done,
  output logic [AW-1:0] mark_addr,
  input  logic          mark_bit,
  output logic          mark_clr,
  output logic          clear_valid,
  output logic [AW-1:0] clear_addr
);
  import rae_pkg::*;
  localparam logic [AW-1:0] THR = AW'(THRESH);

  logic [AW-1:0] pop_addr, lvl_nxt, ptr;
  logic          empty, visit, slot_we;
  slot_t         slot_rd, slot_wv;

  rae_free_stack #(.N(N)) u_stack (
    .clk(clk), .rst_n(rst_n), .pop(alloc_req), .push(clear_valid),
    .push_addr(clear_addr), .pop_addr(pop_addr), .empty(empty),
    .lvl_nxt(lvl_nxt)
  );

  rae_slot_map #(.N(N)) u_slots (
    .clk(clk), .rst_n(rst_n), .fresh_en(alloc_req && !empty),
    .fresh_addr(pop_addr), .sw_en(slot_we), .sw_addr(ptr),
    .sw_val(slot_wv), .sw_rd(slot_rd)
  );

  rae_sweep_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .low(lvl_nxt < THR),
    .trace_done(trace_done), .mark_bit(mark_bit), .slot_rd(slot_rd),
    .ptr(ptr), .visit(visit), .slot_we(slot_we), .slot_wv(slot_wv),
    .gc_start(gc_start), .rec_v(clear_valid), .rec_a(clear_addr)
  );

  assign mark_addr = ptr;
  assign mark_clr  = visit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_vld  <= 1'b0;
      alloc_addr <= '0;
      oom        <= 1'b0;
    end else begin
      alloc_vld  <= alloc_req;
      alloc_addr <= alloc_req ? pop_addr : '0;
      oom        <= alloc_req && empty;
    end
  end
endmodule

// File: rtl/reclaim_alloc_engine_chk.sv
module reclaim_alloc_engine_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_req,
  input logic          alloc_vld,
  input logic [AW-1:0] alloc_addr,
  input logic          oom,
  input logic          gc_start,
  input logic [AW-1:0] mark_addr,
  input logic          mark_clr,
  input logic          clear_valid,
  input logic [AW-1:0] clear_addr
);
  // R4
  gc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_start |=> !gc_start);
  // R3
  oom_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_vld && oom) |-> (alloc_addr == '0));
  // R2
  vld_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> alloc_vld);
  // R6
  preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_clr |-> !alloc_req);
  // R8
  clear_after_visit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_valid |-> ($past(mark_clr) && $past(mark_addr) == clear_addr));
  // R5
  no_null_visit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_clr |-> (mark_addr != '0));
endmodule

bind reclaim_alloc_engine reclaim_alloc_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_vld(alloc_vld),
  .alloc_addr(alloc_addr), .oom(oom), .gc_start(gc_start),
  .mark_addr(mark_addr), .mark_clr(mark_clr), .clear_valid(clear_valid),
  .clear_addr(clear_addr)
);

// File: tb/reclaim_alloc_engine_test.sv
`timescale 1ns/1ps
module reclaim_alloc_engine_test;
  localparam int N  = 16;
  localparam int TH = N / 4;
  localparam int AW = $clog2(N);

  logic clk = 0, rst_n = 0, alloc_req = 0, trace_done = 0;
  logic alloc_vld, oom, gc_start, mark_clr, clear_valid;
  logic [AW-1:0] alloc_addr, mark_addr, clear_addr;
  logic mark_bit;
  bit   marks [N];

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;
  assign mark_bit = marks[mark_addr];

  reclaim_alloc_engine #(.N(N), .THRESH(TH)) uut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_vld(alloc_vld),
    .alloc_addr(alloc_addr), .oom(oom), .gc_start(gc_start),
    .trace_done(trace_done), .mark_addr(mark_addr), .mark_bit(mark_bit),
    .mark_clr(mark_clr), .clear_valid(clear_valid), .clear_addr(clear_addr)
  );

  // reference model state
  int mstk [N];
  int mtop, mph, mptr, mp, mpa;
  int mused [N];
  int e_vld, e_addr, e_oom, e_gc, e_cv, e_ca;
  string e_atag, e_ctag;
  bit clr_pend;
  int clr_slot;

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  function automatic int marks_set();
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(marks[i]);
    return c;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin mstk[i] = i + 1; mused[i] = 0; marks[i] = 0; end
    mtop = N - 1; mph = 0; mptr = 0; mp = 0; mpa = 0;
    e_vld = 0; e_addr = 0; e_oom = 0; e_gc = 0; e_cv = 0; e_ca = 0;
    e_atag = "R2"; e_ctag = "R9"; clr_pend = 0;
  endtask

  // one cycle: check delayed outputs, drive inputs, check combinational, step model
  task automatic step(input bit a, input bit td);
    int np = 0, npa = 0, was_empty, vis;
    @(negedge clk);
    cyc++;
    if (clr_pend) marks[clr_slot] = 0;
    clr_pend = 0;
    chk(e_atag, int'(alloc_vld), e_vld);
    if (e_vld != 0) begin
      chk(e_atag, int'(alloc_addr), e_addr);
      chk("R3", int'(oom), e_oom);
    end
    chk("R4", int'(gc_start), e_gc);
    chk(e_ctag, int'(clear_valid), e_cv);
    if (e_cv != 0) chk("R8", int'(clear_addr), e_ca);
    alloc_req = a; trace_done = td;
    #1;
    vis = (mph == 2 && !a) ? 1 : 0;
    chk((mph == 2 && a) ? "R6" : "R5", int'(mark_clr), vis);
    if (vis != 0) begin
      chk("R5", int'(mark_addr), mptr);
      clr_pend = 1; clr_slot = mptr;
    end
    // model
    was_empty = (mtop == 0);
    e_atag = "R2";
    e_vld = a; e_oom = (a && was_empty) ? 1 : 0;
    e_addr = (a && !was_empty) ? mstk[mtop-1] : 0;
    if (a && !was_empty) begin
      if (mp != 0) begin mstk[mtop-1] = mpa; e_atag = "R10"; end
      else mtop--;
      mused[e_addr] = 1;
    end else if (mp != 0) begin
      mstk[mtop] = mpa; mtop++;
    end
    e_gc = 0; e_ctag = "R9";
    if (mph == 0) begin
      if (a && mtop < TH) begin e_gc = 1; mph = 1; end
    end else if (mph == 1) begin
      if (td) begin mph = 2; mptr = 1; end
    end else if (vis != 0) begin
      if (marks[mptr]) begin mused[mptr] = 2; e_ctag = "R7"; end
      else if (mused[mptr] == 2) begin mused[mptr] = 0; np = 1; npa = mptr; e_ctag = "R8"; end
      if (mptr == N - 1) mph = 0; else mptr++;
    end
    mp = np; mpa = npa; e_cv = np; e_ca = npa;
  endtask

  initial begin
    int wait_td, sweeps;
    bit armed;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", int'(alloc_vld), 0);
    chk("R1", int'(gc_start), 0);
    chk("R1", int'(clear_valid), 0);
    @(negedge clk); rst_n = 1;
    // directed: drain the whole stack, then one request too many
    for (int i = 0; i < N; i++) begin
      step(1, 0);
      if (i > 0) chk("R1", int'(alloc_addr), N - i);
    end
    step(0, 0);
    chk("R3", int'(oom), 1);
    chk("R3", int'(alloc_addr), 0);
    // trace_done before any wait phase would be ignored; here phase is trace
    // random phase
    void'($urandom(32'h5eed_0042));
    armed = 0; wait_td = 0; sweeps = 0;
    for (int k = 0; k < 6000; k++) begin
      bit a, td;
      a  = ($urandom % 100) < 35;
      td = 0;
      if (mph == 1) begin
        if (!armed) begin
          chk("R11", marks_set(), 0);
          for (int i = 1; i < N; i++)
            if (mused[i] != 0) marks[i] = ($urandom % 2) == 1;
          armed = 1; wait_td = 1 + int'($urandom % 6);
        end else if (wait_td == 0) begin
          td = 1; armed = 0; sweeps++;
        end else wait_td--;
      end else begin
        td = ($urandom % 50) == 0; // ignored outside the wait phase (R5)
      end
      step(a, td);
    end
    step(0, 0);
    if (mph == 0) chk("R11", marks_set(), 0);
    chk("R4", int'(sweeps > 3), 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule